// File: doc/BRIEF.md
# Shadowed Register Update Sequencer

This block sits between a fast host-side register file and a slow, always-on copy of the same registers. The host writes any of eight words at full clock rate into shadow registers. The block then carries each written word over to its slow copy, one register at a time. Indices 0 to 5 are the six persistent words, index 6 is the alarm word and index 7 is the seconds word. The slow domain is modelled as a single-cycle clock-enable pulse, `slow_tick`. Each copy takes a fixed number of those pulses, set by a parameter so that simulation can use a short value.

For every register the block keeps a pending flag and a completion flag, and it shows both in one status word. Software polls the pending flag of a register to learn when the slow copy holds what it wrote. Software polls the seconds flag (mask 0x80 in the pending field) to know that a full pass has finished. A force request marks every register pending at once. Bit 31 of the slow copy of persistent word 1 comes out as the force-update control that goes together with watchdog enable changes.

Top module: `shadow_sync_seq`

## Requirements
- R1: After reset, the status word is zero and every slow copy reads zero, so `force_update_o` is 0.
- R2: A host write (`wr_en`) to index k stores `wr_data` in shadow k and sets pending bit k, which is status bit 16+k, by the next cycle. The slow copy k does not change at that point.
- R3: Only one copy runs at a time. When the block is idle and any pending bit is set, it starts the lowest-indexed pending register, in the order persistent 0..5, then alarm (6), then seconds (7).
- R4: A copy that starts on an edge completes on the COPY_TICKS-th later edge at which `slow_tick` is high. The slow copy does not change before that edge. On that edge it takes the shadow value that was present when the copy started.
- R5: When a copy of index k completes, it sets completion bit k (status bit k) and clears pending bit k, unless R7 applies.
- R6: Completion bits stay set until `new_clr` is high with that bit set in `new_clr_mask`. If a completion and a clear hit the same bit on the same edge, the bit ends up set.
- R7: If index k is written, or a force request arrives, while the copy of k is in progress or on its completion edge, pending bit k stays set. A further copy of k then carries the newest value.
- R8: `force_req` sets all eight pending bits on the next cycle, and a full pass follows in the R3 order.
- R9: `force_update_o` equals bit 31 of the slow copy of persistent word 1.
- R10: Status bits [15:8] and [31:24] always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle slow-domain enable pulse |
| wr_en | input | 1 | Host write strobe |
| wr_idx | input | 3 | Register index of the write |
| wr_data | input | 32 | Write data |
| force_req | input | 1 | Marks every register pending |
| new_clr | input | 1 | Strobe that clears completion bits |
| new_clr_mask | input | 8 | Completion bits to clear |
| rd_idx | input | 3 | Selects the slow copy to read |
| slow_rd_data | output | 32 | Slow copy at `rd_idx` |
| status_o | output | 32 | Pending field [23:16], completion field [7:0] |
| force_update_o | output | 1 | Slow persistent 1 bit 31 |

## Verification
Two pairs of functions can land on the same edge. In the first pair, a host write or force request hits the register whose copy finishes on that edge. In the second pair, a completion-bit clear meets the completion that sets the same bit. The bench sets up both on purpose. It counts slow ticks after a lone write so that the clear lands on the completion edge. It also rewrites a register while that register's copy is in flight. Random traffic then repeats both overlaps many times. On every cycle the status fields and the slow copies are compared with a reference model built from the requirements. The checks confirm two outcomes: the completion bit wins over the clear, and the rewritten register stays pending until a later copy delivers the newest value.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
    localparam int SSQ_NREG      = 8;
    localparam int SSQ_DW        = 32;
    localparam int SSQ_STALE_LSB = 16;
    localparam int SSQ_NEW_LSB   = 0;
    localparam int SSQ_FORCE_REG = 1;
    localparam int SSQ_FORCE_BIT = 31;
endpackage

// File: rtl/ssq_pick.sv
// Lowest-index pending request finder.
module ssq_pick #(
    parameter int NREG = 8,
    localparam int IW = $clog2(NREG)
) (
    input  logic [NREG-1:0] req,
    output logic            found,
    output logic [IW-1:0]   idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/ssq_timer.sv
// Counts slow ticks for one copy; expire marks the final tick.
module ssq_timer #(
    parameter int TICKS = 4,
    localparam int CW = $clog2(TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic expire
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = CW'(TICKS);
        else if (tick && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = tick && (cnt_q == CW'(1));
endmodule

// File: rtl/ssq_bank.sv
// Shadow words (host side) and their slow-domain copies.
module ssq_bank #(
    parameter int NREG = 8,
    parameter int DW   = 32,
    parameter int FREG = 1,
    parameter int FBIT = 31,
    localparam int IW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] snap_idx,
    output logic [DW-1:0] snap_data,
    input  logic          commit_en,
    input  logic [IW-1:0] commit_idx,
    input  logic [DW-1:0] commit_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic          force_bit
);
    logic [DW-1:0] sh_d [NREG];
    logic [DW-1:0] sh_q [NREG];
    logic [DW-1:0] sl_d [NREG];
    logic [DW-1:0] sl_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_word
        always_comb begin
            sh_d[g] = (wr_en && wr_idx == IW'(g)) ? wr_data : sh_q[g];
            sl_d[g] = (commit_en && commit_idx == IW'(g)) ? commit_data : sl_q[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_q[g] <= '0;
                sl_q[g] <= '0;
            end else begin
                sh_q[g] <= sh_d[g];
                sl_q[g] <= sl_d[g];
            end
        end
    end

    assign snap_data = sh_q[snap_idx];
    assign rd_data   = sl_q[rd_idx];
    assign force_bit = sl_q[FREG][FBIT];
endmodule

// File: rtl/shadow_sync_seq.sv
module shadow_sync_seq #(
    parameter int COPY_TICKS = 4,
    localparam int NREG = ssq_pkg::SSQ_NREG,
    localparam int DW   = ssq_pkg::SSQ_DW,
    localparam int IW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            slow_tick,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic            force_req,
    input  logic            new_clr,
    input  logic [NREG-1:0] new_clr_mask,
    input  logic [IW-1:0]   rd_idx,
    output logic [DW-1:0]   slow_rd_data,
    output logic [31:0]     status_o,
    output logic            force_update_o
);
    typedef struct packed {
        logic            busy;
        logic [IW-1:0]   cur;
        logic            rew;
        logic [DW-1:0]   snap;
        logic [NREG-1:0] stale;
        logic [NREG-1:0] newb;
    } seq_t;

    seq_t st_d, st_q;

    logic            pick_found;
    logic [IW-1:0]   pick_idx;
    logic [DW-1:0]   shadow_word;
    logic            timer_load;
    logic            timer_exp;
    logic            commit_en;
    logic [NREG-1:0] set_mask;

    ssq_pick #(.NREG(NREG)) u_pick (
        .req   (st_q.stale),
        .found (pick_found),
        .idx   (pick_idx)
    );

    ssq_timer #(.TICKS(COPY_TICKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (timer_load),
        .tick   (slow_tick),
        .expire (timer_exp)
    );

    ssq_bank #(
        .NREG (NREG),
        .DW   (DW),
        .FREG (ssq_pkg::SSQ_FORCE_REG),
        .FBIT (ssq_pkg::SSQ_FORCE_BIT)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .snap_idx    (pick_idx),
        .snap_data   (shadow_word),
        .commit_en   (commit_en),
        .commit_idx  (st_q.cur),
        .commit_data (st_q.snap),
        .rd_idx      (rd_idx),
        .rd_data     (slow_rd_data),
        .force_bit   (force_update_o)
    );

    always_comb begin
        logic [NREG-1:0] done_mask;
        logic [NREG-1:0] clr_stale;
        st_d       = st_q;
        done_mask  = '0;
        clr_stale  = '0;
        commit_en  = 1'b0;
        timer_load = 1'b0;
        set_mask   = (force_req ? {NREG{1'b1}} : '0)
                   | (wr_en ? (NREG'(1) << wr_idx) : '0);

        if (!st_q.busy) begin
            if (pick_found) begin
                st_d.busy  = 1'b1;
                st_d.cur   = pick_idx;
                st_d.rew   = set_mask[pick_idx];
                st_d.snap  = shadow_word;
                timer_load = 1'b1;
            end
        end else begin
            st_d.rew = st_q.rew | set_mask[st_q.cur];
            if (timer_exp) begin
                commit_en = 1'b1;
                st_d.busy = 1'b0;
                done_mask = NREG'(1) << st_q.cur;
                if (!(st_q.rew || set_mask[st_q.cur]))
                    clr_stale = done_mask;
            end
        end

        st_d.stale = (st_q.stale & ~clr_stale) | set_mask;
        st_d.newb  = (st_q.newb & ~(new_clr ? new_clr_mask : '0)) | done_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status_o = '0;
        status_o[ssq_pkg::SSQ_STALE_LSB +: NREG] = st_q.stale;
        status_o[ssq_pkg::SSQ_NEW_LSB   +: NREG] = st_q.newb;
    end
endmodule

// File: rtl/ssq_checks.sv
module ssq_checks #(
    parameter int NREG = 8,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NREG),
    localparam int SL  = ssq_pkg::SSQ_STALE_LSB,
    localparam int NL  = ssq_pkg::SSQ_NEW_LSB
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [IW-1:0] wr_idx,
    input logic          force_req,
    input logic [IW-1:0] rd_idx,
    input logic [DW-1:0] slow_rd_data,
    input logic [31:0]   status_o
);
    logic [NREG-1:0] stale_v, new_v;
    assign stale_v = status_o[SL +: NREG];
    assign new_v   = status_o[NL +: NREG];

    assert_write_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> stale_v[$past(wr_idx)]);

    assert_one_at_a_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(new_v & ~$past(new_v)) <= 1);

    assert_clear_needs_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stale_v) & ~stale_v & ~new_v) == '0));

    assert_copy_flags_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(rd_idx) && !$stable(slow_rd_data)) |-> new_v[rd_idx]);

    assert_force_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        force_req |=> (stale_v == {NREG{1'b1}}));

    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[15:8] == 8'h00) && (status_o[31:24] == 8'h00));
endmodule

bind shadow_sync_seq ssq_checks #(.NREG(ssq_pkg::SSQ_NREG), .DW(ssq_pkg::SSQ_DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .force_req    (force_req),
    .rd_idx       (rd_idx),
    .slow_rd_data (slow_rd_data),
    .status_o     (status_o)
);

// File: tb/tb_shadow_sync_seq.sv
`timescale 1ns/1ps
module tb_shadow_sync_seq;
    localparam int T = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0, wr_en = 1'b0, force_req = 1'b0, new_clr = 1'b0;
    logic [2:0]  wr_idx = '0, rd_idx = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  new_clr_mask = '0;
    logic [31:0] slow_rd_data, status_o;
    logic        force_update_o;

    int checks = 0, failures = 0, cycles = 0;

    // reference model state
    logic [7:0]  m_stale = '0, m_new = '0;
    logic        m_busy = 1'b0, m_rew = 1'b0;
    logic [2:0]  m_cur = '0;
    int          m_cnt = 0;
    logic [31:0] m_snap = '0;
    logic [31:0] m_sh [8];
    logic [31:0] m_sl [8];

    shadow_sync_seq #(.COPY_TICKS(T)) dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .force_req(force_req),
        .new_clr(new_clr), .new_clr_mask(new_clr_mask), .rd_idx(rd_idx),
        .slow_rd_data(slow_rd_data), .status_o(status_o),
        .force_update_o(force_update_o)
    );

    always #2 clk = ~clk;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog act=%0d exp<=150000", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int lowest(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic model_step(logic we, logic [2:0] idx, logic [31:0] d,
                              logic ce, logic [7:0] cm, logic fr, logic tk);
        logic [7:0] setm, done, clr;
        setm = (fr ? 8'hFF : 8'h00) | (we ? (8'h01 << idx) : 8'h00);
        done = '0;
        clr  = '0;
        if (!m_busy) begin
            if (m_stale != 0) begin
                m_cur  = 3'(lowest(m_stale));
                m_busy = 1'b1;
                m_rew  = setm[m_cur];
                m_snap = m_sh[m_cur];
                m_cnt  = T;
            end
        end else begin
            if (tk && m_cnt == 1) begin
                m_sl[m_cur] = m_snap;
                done = 8'h01 << m_cur;
                if (!(m_rew || setm[m_cur])) clr = done;
                m_busy = 1'b0;
            end else if (tk) begin
                m_cnt--;
            end
            m_rew = m_rew | setm[m_cur];
        end
        m_stale = (m_stale & ~clr) | setm;
        m_new   = (m_new & ~(ce ? cm : 8'h00)) | done;
        if (we) m_sh[idx] = d;
    endtask

    // One cycle: compare at negedge, drive the next inputs, advance the model.
    task automatic cyc(logic we, logic [2:0] idx, logic [31:0] d, logic ce,
                       logic [7:0] cm, logic fr, logic tk, logic [2:0] rsel);
        @(negedge clk);
        chk("R3 pending field", {24'h0, status_o[23:16]}, {24'h0, m_stale});
        chk("R5 completion field", {24'h0, status_o[7:0]}, {24'h0, m_new});
        chk("R4 slow copy", slow_rd_data, m_sl[rd_idx]);
        chk("R9 force output", {31'h0, force_update_o}, {31'h0, m_sl[1][31]});
        chk("R10 reserved bits", {status_o[31:24], status_o[15:8]}, 32'h0);
        wr_en = we; wr_idx = idx; wr_data = d; new_clr = ce; new_clr_mask = cm;
        force_req = fr; slow_tick = tk; rd_idx = rsel;
        model_step(we, idx, d, ce, cm, fr, tk);
    endtask

    task automatic idle(logic tk);
        cyc(1'b0, 3'd0, 32'h0, 1'b0, 8'h00, 1'b0, tk, rd_idx);
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && (m_busy || m_stale != 0); i++) idle(1'b1);
        idle(1'b0);
        idle(1'b0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin m_sh[i] = '0; m_sl[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 8; i++) begin
            rd_idx = 3'(i);
            #0.5;
            chk("R1 slow copy reset", slow_rd_data, 32'h0);
        end
        chk("R1 status reset", status_o, 32'h0);
        chk("R1 force reset", {31'h0, force_update_o}, 32'h0);
        rst_n = 1'b1;
        rd_idx = 3'd0;

        // R2: write sets pending, slow copy unchanged
        cyc(1'b1, 3'd6, 32'hA1A1_0006, 1'b0, 8'h00, 1'b0, 1'b0, 3'd6);
        idle(1'b0);
        chk("R2 pending bit 22 after write", {31'h0, status_o[22]}, 32'h1);
        chk("R2 slow copy unchanged", slow_rd_data, 32'h0);
        drain();
        chk("R4 alarm copy delivered", slow_rd_data, 32'hA1A1_0006);

        // R3: order among pending registers
        cyc(1'b1, 3'd7, 32'h0000_0777, 1'b0, 8'h00, 1'b0, 1'b0, 3'd7);
        cyc(1'b1, 3'd5, 32'h0000_0555, 1'b1, 8'hFF, 1'b0, 1'b0, 3'd7);
        cyc(1'b1, 3'd3, 32'h0000_0333, 1'b0, 8'h00, 1'b0, 1'b0, 3'd7);
        for (int i = 0; i < 200 && !status_o[3]; i++) idle(1'b1);
        chk("R3 index 3 done before index 5", {31'h0, status_o[5]}, 32'h0);
        drain();

        // R6: clear meets completion on the same edge; completion wins
        cyc(1'b1, 3'd0, 32'h1234_5678, 1'b1, 8'hFF, 1'b0, 1'b0, 3'd0);
        idle(1'b0);                 // copy starts on this edge
        for (int i = 0; i < T - 1; i++) idle(1'b1);
        cyc(1'b0, 3'd0, 32'h0, 1'b1, 8'h01, 1'b0, 1'b1, 3'd0);
        idle(1'b0);
        chk("R6 completion wins over clear", {31'h0, status_o[0]}, 32'h1);
        chk("R4 copy after T ticks", slow_rd_data, 32'h1234_5678);
        cyc(1'b0, 3'd0, 32'h0, 1'b1, 8'h01, 1'b0, 1'b0, 3'd0);
        idle(1'b0);
        chk("R6 clear alone drops bit", {31'h0, status_o[0]}, 32'h0);

        // R7: rewrite during the copy
        cyc(1'b1, 3'd4, 32'h0000_4444, 1'b0, 8'h00, 1'b0, 1'b0, 3'd4);
        idle(1'b0);
        cyc(1'b1, 3'd4, 32'h4444_0000, 1'b0, 8'h00, 1'b0, 1'b0, 3'd4);
        for (int i = 0; i < 200 && !status_o[4]; i++) idle(1'b1);
        chk("R7 pending kept after first copy", {31'h0, status_o[20]}, 32'h1);
        drain();
        chk("R7 newest value delivered", slow_rd_data, 32'h4444_0000);

        // R9: force-update control bit
        cyc(1'b1, 3'd1, 32'h8000_0001, 1'b0, 8'h00, 1'b0, 1'b0, 3'd1);
        drain();
        chk("R9 force bit set", {31'h0, force_update_o}, 32'h1);

        // R8: force request
        cyc(1'b0, 3'd0, 32'h0, 1'b1, 8'hFF, 1'b1, 1'b0, 3'd0);
        idle(1'b0);
        chk("R8 all pending", {24'h0, status_o[23:16]}, 32'hFF);
        drain();
        chk("R8 full pass completed", {24'h0, status_o[7:0]}, 32'hFF);

        // random mix
        void'($urandom(32'h5EED_0042));
        for (int n = 0; n < 4000; n++) begin
            logic we, ce, fr, tk;
            we = ($urandom % 8) == 0;
            ce = ($urandom % 16) == 0;
            fr = ($urandom % 300) == 0;
            tk = ($urandom % 3) == 0;
            cyc(we, 3'($urandom), $urandom, ce, 8'($urandom), fr, tk, 3'($urandom));
        end
        drain();
        summary();
        $finish;
    end
endmodule